// File: doc/BRIEF.md
# Radix-2 Butterfly with Conditional Block Scaling

This block is the arithmetic core of a fixed-point FFT of configurable power-of-two length, 2 up to 256 points. Each cycle it may accept one decimation-in-time butterfly: two complex operands A and B, each component a 17-bit stored word (16 arithmetic bits plus one guard bit), and one complex 16-bit Q1.15 twiddle W. It returns A + B·W and A − B·W as 17-bit words, ready to be written back to data memory. The memory, the address sequencing and the twiddle storage stay outside the block.

Scaling is not applied by default at each stage. While a stage's results are produced, the block records whether any of them has used the guard bit. When the next stage begins, all of that stage's operands are halved with round-half-up if growth was seen, and a block exponent counts the halvings. The shift sits in the first pipeline register, which a butterfly needs anyway, so scaling costs no cycle. The feeder marks the first beat of every stage, the first beat of a new transform and the beats of the final stage. It must let one stage drain (four cycles) before starting the next, which the read-after-write dependency through memory already forces.

Top module: `bfly_r2_scaled`

## Requirements
- R1: After reset `out_valid` is low and `blk_exp` is 0. Each accepted beat produces exactly one result beat, whose `out_valid` rises after the fourth rising edge counting the edge that sampled the input. One beat can be accepted per cycle.
- R2: With the operands A and B taken after any scaling, T_re = (B_re·W_re − B_im·W_im + 2^14) >>> 15 and T_im = (B_re·W_im + B_im·W_re + 2^14) >>> 15, using an arithmetic shift. The results are X = A + T and Y = A − T, per component.
- R3: Every result component is saturated to the 17-bit signed range [−65536, 65535].
- R4: The growth flag is set when any result component of a beat lies outside [−32768, 32767], that is when bits 16 and 15 of the 17-bit word differ.
- R5: A beat with `first_stage` high clears the growth flag, applies no scaling and sets the exponent to 0.
- R6: A beat with `stage_start` high (without `first_stage`) looks at the growth flag left by the previous stage. If the flag is set, every operand component of the new stage becomes (v + 1) >>> 1 and the exponent is incremented by one. If it is clear, the operands are used unchanged and the exponent is kept. The flag is then cleared.
- R7: The scaling choice made on a stage's first beat holds for every beat of that stage, even if growth occurs during the stage.
- R8: `out_last` is the `last_stage` value of the input beat, aligned with that beat's results.
- R9: `blk_exp` changes only on the edge that samples a stage-start beat. After a transform it equals the number of halvings applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present this cycle |
| first_stage | input | 1 | First beat of a new transform (also starts a stage) |
| stage_start | input | 1 | First beat of a stage |
| last_stage | input | 1 | Beat belongs to the final stage |
| a_re | input | 17 | Operand A, real part, signed |
| a_im | input | 17 | Operand A, imaginary part, signed |
| b_re | input | 17 | Operand B, real part, signed |
| b_im | input | 17 | Operand B, imaginary part, signed |
| w_re | input | 16 | Twiddle real part, signed Q1.15 |
| w_im | input | 16 | Twiddle imaginary part, signed Q1.15 |
| out_valid | output | 1 | Result beat present |
| out_last | output | 1 | Result belongs to the final stage |
| x_re | output | 17 | A + B·W, real part |
| x_im | output | 17 | A + B·W, imaginary part |
| y_re | output | 17 | A − B·W, real part |
| y_im | output | 17 | A − B·W, imaginary part |
| blk_exp | output | 4 | Total halvings applied in the current transform |

## Verification
The bench builds the block with its default widths: 17-bit data, 16-bit twiddles and a limit of eight stages. With these settings it can drive complete transforms of 2, 8, 16, 32, 64 and 256 points, sweeping every butterfly of every stage against an arithmetic model. Full-scale inputs of both signs push the exponent to its highest values, small inputs keep it at zero, and extreme 17-bit operands reach the saturation limits. A run with small data directly after a full-scale one shows that a new transform starts from a clean growth flag and exponent.

// File: rtl/bfly_r2_scaled.sv
module bfly_r2_scaled #(
  parameter int DW = 17,
  parameter int WW = 16,
  parameter int MAX_LOG = 8,
  localparam int EW = $clog2(MAX_LOG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 first_stage,
  input  logic                 stage_start,
  input  logic                 last_stage,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [WW-1:0] w_re,
  input  logic signed [WW-1:0] w_im,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [DW-1:0] x_re,
  output logic signed [DW-1:0] x_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im,
  output logic [EW-1:0]        blk_exp
);
  localparam int FB = WW - 1;
  localparam int PW = DW + WW;
  localparam int TW = PW - FB + 1;
  localparam logic signed [PW:0] RND  = {{(PW + 1 - FB){1'b0}}, 1'b1, {(FB - 1){1'b0}}};
  localparam logic signed [TW:0] SMAX = {{(TW - DW + 2){1'b0}}, {(DW - 1){1'b1}}};
  localparam logic signed [TW:0] SMIN = {{(TW - DW + 2){1'b1}}, {(DW - 1){1'b0}}};

  function automatic logic signed [DW-1:0] half(input logic signed [DW-1:0] v);
    logic [DW:0] t;
    t = {v[DW-1], v} + {{DW{1'b0}}, 1'b1};
    return t[DW:1];
  endfunction

  function automatic logic signed [DW-1:0] sat(input logic signed [TW:0] v);
    if (v > SMAX) return SMAX[DW-1:0];
    if (v < SMIN) return SMIN[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic start, scale_now, scale_q, grow_q;
  logic [EW-1:0] exp_q;

  logic v1, v2, v3, l1, l2, l3;
  logic signed [DW-1:0] a1r, a1i, b1r, b1i, a2r, a2i, a3r, a3i;
  logic signed [WW-1:0] w1r, w1i;
  logic signed [PW-1:0] prr, pii, pri, pir;
  logic signed [PW:0]   sr, si;
  logic signed [TW-1:0] tr, ti;
  logic signed [TW:0]   ur, ui, dr, di;
  logic signed [DW-1:0] sxr, sxi, syr, syi;
  logic big;

  assign start     = in_valid & (stage_start | first_stage);
  assign scale_now = start ? (grow_q & ~first_stage) : scale_q;

  // twiddle product, rounded from Q1.15 back to data scale
  assign sr = (PW+1)'(prr) - (PW+1)'(pii) + RND;
  assign si = (PW+1)'(pri) + (PW+1)'(pir) + RND;

  assign ur = (TW+1)'(a3r) + (TW+1)'(tr);
  assign ui = (TW+1)'(a3i) + (TW+1)'(ti);
  assign dr = (TW+1)'(a3r) - (TW+1)'(tr);
  assign di = (TW+1)'(a3i) - (TW+1)'(ti);

  assign sxr = sat(ur);
  assign sxi = sat(ui);
  assign syr = sat(dr);
  assign syi = sat(di);

  // guard bit in use when the two top bits differ
  assign big = (sxr[DW-1] ^ sxr[DW-2]) | (sxi[DW-1] ^ sxi[DW-2]) |
               (syr[DW-1] ^ syr[DW-2]) | (syi[DW-1] ^ syi[DW-2]);

  assign blk_exp = exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= 1'b0;
      grow_q  <= 1'b0;
      exp_q   <= '0;
    end else if (start) begin
      scale_q <= scale_now;
      grow_q  <= 1'b0;
      exp_q   <= first_stage ? '0 : exp_q + EW'(scale_now);
    end else if (v3 && big) begin
      grow_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; out_valid <= 1'b0;
      l1 <= 1'b0; l2 <= 1'b0; l3 <= 1'b0; out_last  <= 1'b0;
      a1r <= '0; a1i <= '0; b1r <= '0; b1i <= '0; w1r <= '0; w1i <= '0;
      a2r <= '0; a2i <= '0; prr <= '0; pii <= '0; pri <= '0; pir <= '0;
      a3r <= '0; a3i <= '0; tr  <= '0; ti  <= '0;
      x_re <= '0; x_im <= '0; y_re <= '0; y_im <= '0;
    end else begin
      v1  <= in_valid;
      l1  <= last_stage;
      a1r <= scale_now ? half(a_re) : a_re;
      a1i <= scale_now ? half(a_im) : a_im;
      b1r <= scale_now ? half(b_re) : b_re;
      b1i <= scale_now ? half(b_im) : b_im;
      w1r <= w_re;
      w1i <= w_im;

      v2  <= v1;
      l2  <= l1;
      a2r <= a1r;
      a2i <= a1i;
      prr <= PW'(b1r) * PW'(w1r);
      pii <= PW'(b1i) * PW'(w1i);
      pri <= PW'(b1r) * PW'(w1i);
      pir <= PW'(b1i) * PW'(w1r);

      v3  <= v2;
      l3  <= l2;
      a3r <= a2r;
      a3i <= a2i;
      tr  <= sr[PW:FB];
      ti  <= si[PW:FB];

      out_valid <= v3;
      out_last  <= l3;
      x_re <= sxr;
      x_im <= sxi;
      y_re <= syr;
      y_im <= syi;
    end
  end
endmodule

module bfly_r2_scaled_chk #(
  parameter int DW = 17,
  parameter int EW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          first_stage,
  input logic          stage_start,
  input logic          out_valid,
  input logic          grow_q,
  input logic [DW-1:0] x_re,
  input logic [DW-1:0] x_im,
  input logic [DW-1:0] y_re,
  input logic [DW-1:0] y_im,
  input logic [EW-1:0] blk_exp
);
  logic [3:0] vh;
  logic any_big;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vh <= '0;
    else        vh <= {vh[2:0], in_valid};

  assign any_big = (x_re[DW-1] ^ x_re[DW-2]) | (x_im[DW-1] ^ x_im[DW-2]) |
                   (y_re[DW-1] ^ y_re[DW-2]) | (y_im[DW-1] ^ y_im[DW-2]);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vh[3]);

  assert_first_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && first_stage) |=> (blk_exp == '0) && !grow_q);

  assert_exp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && stage_start && !first_stage) |=>
      blk_exp == $past(blk_exp) + EW'($past(grow_q)));

  assert_exp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (stage_start || first_stage)) |=> $stable(blk_exp));

  assert_growth_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && any_big) |-> grow_q);
endmodule

bind bfly_r2_scaled bfly_r2_scaled_chk #(.DW(DW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_stage(first_stage),
  .stage_start(stage_start), .out_valid(out_valid), .grow_q(grow_q),
  .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im), .blk_exp(blk_exp));

// File: tb/bfly_r2_scaled_tb.sv
module bfly_r2_scaled_tb;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, first_stage, stage_start, last_stage;
  logic signed [16:0] a_re, a_im, b_re, b_im;
  logic signed [15:0] w_re, w_im;
  logic out_valid, out_last;
  logic signed [16:0] x_re, x_im, y_re, y_im;
  logic [3:0] blk_exp;

  bfly_r2_scaled u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_stage(first_stage),
    .stage_start(stage_start), .last_stage(last_stage),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .out_valid(out_valid), .out_last(out_last),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im), .blk_exp(blk_exp));

  int checks = 0, failures = 0;
  bit finished = 0;
  int mre[256], mim[256];
  int ia[128], ib[128], twr[128], twi[128];
  int exr[128], exi[128], eyr[128], eyi[128];
  int cxr[128], cxi[128], cyr[128], cyi[128];
  bit clst[128];
  int cap_n = 0;
  bit ref_grow = 0;
  int ref_exp = 0;

  always @(negedge clk)
    if (out_valid && cap_n < 128) begin
      cxr[cap_n] = int'(x_re);
      cxi[cap_n] = int'(x_im);
      cyr[cap_n] = int'(y_re);
      cyi[cap_n] = int'(y_im);
      clst[cap_n] = out_last;
      cap_n = cap_n + 1;
    end

  function automatic int half(int v);
    return (v + 1) >>> 1;
  endfunction

  function automatic int sat17(int v);
    if (v > 65535) return 65535;
    if (v < -65536) return -65536;
    return v;
  endfunction

  function automatic bit ovr(int v);
    return (v > 32767) || (v < -32768);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic run_stage(input int nb, input bit fs, input bit ls, input string tag);
    bit sc;
    sc = fs ? 1'b0 : ref_grow;
    ref_exp = fs ? 0 : ref_exp + int'(sc);
    ref_grow = 0;
    cap_n = 0;
    for (int k = 0; k < nb; k++) begin
      int ar, ai, br, bi, tr, ti;
      longint pr, pim;
      ar = sc ? half(mre[ia[k]]) : mre[ia[k]];
      ai = sc ? half(mim[ia[k]]) : mim[ia[k]];
      br = sc ? half(mre[ib[k]]) : mre[ib[k]];
      bi = sc ? half(mim[ib[k]]) : mim[ib[k]];
      pr  = longint'(br) * twr[k] - longint'(bi) * twi[k] + 16384;
      pim = longint'(br) * twi[k] + longint'(bi) * twr[k] + 16384;
      tr = int'(pr >>> 15);
      ti = int'(pim >>> 15);
      exr[k] = sat17(ar + tr);
      exi[k] = sat17(ai + ti);
      eyr[k] = sat17(ar - tr);
      eyi[k] = sat17(ai - ti);
      a_re = 17'(mre[ia[k]]);
      a_im = 17'(mim[ia[k]]);
      b_re = 17'(mre[ib[k]]);
      b_im = 17'(mim[ib[k]]);
      w_re = 16'(twr[k]);
      w_im = 16'(twi[k]);
      in_valid = 1'b1;
      stage_start = (k == 0);
      first_stage = fs && (k == 0);
      last_stage = ls;
      @(negedge clk);
    end
    in_valid = 1'b0;
    stage_start = 1'b0;
    first_stage = 1'b0;
    last_stage = 1'b0;
    repeat (6) @(negedge clk);
    check(cap_n == nb, "R1", "result beat count", cap_n, nb);
    for (int k = 0; k < nb; k++) begin
      check(cxr[k] == exr[k], tag, "x_re", cxr[k], exr[k]);
      check(cxi[k] == exi[k], tag, "x_im", cxi[k], exi[k]);
      check(cyr[k] == eyr[k], tag, "y_re", cyr[k], eyr[k]);
      check(cyi[k] == eyi[k], tag, "y_im", cyi[k], eyi[k]);
      check(clst[k] == ls, "R8", "out_last", int'(clst[k]), int'(ls));
      mre[ia[k]] = exr[k];
      mim[ia[k]] = exi[k];
      mre[ib[k]] = eyr[k];
      mim[ib[k]] = eyi[k];
      if (ovr(exr[k]) || ovr(exi[k]) || ovr(eyr[k]) || ovr(eyi[k])) ref_grow = 1;
    end
    if (fs) check(int'(blk_exp) == 0, "R5", "exponent after first stage", int'(blk_exp), 0);
    else    check(int'(blk_exp) == ref_exp, "R6", "exponent after stage (R4 growth)",
                  int'(blk_exp), ref_exp);
  endtask

  // mode 0 random 16-bit, 1 full-scale positive, 2 small, 3 full-scale negative
  task automatic run_fft(input int n, input int mode, input string tag);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: begin mre[i] = int'($urandom_range(65535)) - 32768;
                 mim[i] = int'($urandom_range(65535)) - 32768; end
        1: begin mre[i] = 32767;  mim[i] = 32767;  end
        2: begin mre[i] = int'($urandom_range(200)) - 100;
                 mim[i] = int'($urandom_range(200)) - 100; end
        default: begin mre[i] = -32768; mim[i] = -32768; end
      endcase
    end
    for (int h = 1; h < n; h = h * 2) begin
      int nb;
      nb = 0;
      for (int g = 0; g < n; g = g + 2 * h)
        for (int k = 0; k < h; k++) begin
          real ang;
          ang = 2.0 * PI * real'(k * (n / (2 * h))) / real'(n);
          ia[nb] = g + k;
          ib[nb] = g + k + h;
          twr[nb] = int'(32767.0 * $cos(ang));
          twi[nb] = -int'(32767.0 * $sin(ang));
          nb++;
        end
      run_stage(nb, h == 1, 2 * h == n, tag);
    end
    check(int'(blk_exp) == ref_exp, "R9", "final exponent", int'(blk_exp), ref_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; first_stage = 1'b0; stage_start = 1'b0; last_stage = 1'b0;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0; w_re = '0; w_im = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(blk_exp == 4'd0, "R1", "blk_exp after reset", int'(blk_exp), 0);

    // R1 latency: one beat, result must show after the fourth edge
    a_re = 17'sd100; a_im = -17'sd50; b_re = 17'sd10; b_im = 17'sd20;
    w_re = 16'sd32767; w_im = 16'sd0;
    in_valid = 1'b1; first_stage = 1'b1; stage_start = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; first_stage = 1'b0; stage_start = 1'b0;
    check(out_valid == 1'b0, "R1", "valid after edge 1", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after edge 2", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after edge 3", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R1", "valid after edge 4", int'(out_valid), 1);
    check(x_re == 17'sd110, "R2", "latency beat x_re", int'(x_re), 110);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "single result beat", int'(out_valid), 0);
    repeat (2) @(negedge clk);

    // R3 saturation at both ends
    mre[0] = 65535;  mim[0] = 0; mre[1] = 65535;  mim[1] = 0;
    mre[2] = -65536; mim[2] = 0; mre[3] = -65536; mim[3] = 0;
    ia[0] = 0; ib[0] = 1; ia[1] = 2; ib[1] = 3;
    twr[0] = 32767; twi[0] = 0; twr[1] = 32767; twi[1] = 0;
    run_stage(2, 1'b1, 1'b1, "R3");
    check(cxr[0] == 65535, "R3", "positive clamp", cxr[0], 65535);
    check(cxr[1] == -65536, "R3", "negative clamp", cxr[1], -65536);

    run_fft(2, 0, "R2");
    run_fft(8, 0, "R2");
    run_fft(16, 1, "R7");
    run_fft(8, 2, "R5");
    run_fft(256, 0, "R2");
    run_fft(32, 3, "R7");
    run_fft(64, 2, "R6");

    finished = 1;
    summary();
    $finish;
  end
endmodule